// File: doc/BRIEF.md
# Intra 16x16 Plane Predictor

This block produces the plane (gradient) prediction for a 16x16 luma block. It fits a linear surface to the row of sixteen samples above the block, the column of sixteen samples to its left and the single sample diagonally above-left. From these it derives a horizontal slope, a vertical slope and an offset. It then walks the surface one row per clock, so that every predicted sample is produced by repeated addition and not by multiplication.

A caller presents the 33 neighbour samples and pulses `start`. The block captures the neighbours on that edge and spends two cycles deriving the gradient parameters. It then drives sixteen consecutive rows of sixteen 8-bit samples, each marked by `row_valid` and a row number. `done` rises together with the last row. A `start` that arrives while a block is still being produced has no effect.

Top module: `intra_plane16_pred`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `row_valid` and `done` are low.
- R2: When `start` is sampled high by an idle block on clock edge E, row 0 is presented after edge E+2, and row y after edge E+2+y. `row_valid` stays high for exactly 16 consecutive cycles with `row_idx` counting 0 to 15, and is low before and after.
- R3: The horizontal gradient is H = sum for k=1..8 of k*(T[7+k] - T[7-k]) and the vertical gradient is V = sum for k=1..8 of k*(L[7+k] - L[7-k]), where T[i] and L[i] are the above and left samples and T[-1] = L[-1] = the corner sample. The slopes are b = (5*H + 32) >> 6 and c = (5*V + 32) >> 6, using shifts that keep the sign.
- R4: With a = 16*(T[15] + L[15]), the pre-scale value at column x and row y is a + b*(x-7) + c*(y-7) + 16. The hardware starts from a - 7b - 7c + 16, adds b per column and adds c per row.
- R5: Each pre-scale value is clamped to 0..8191 and then shifted right by 5, so a negative value gives 0 and a value of 8192 or more gives 255.
- R6: `done` is high for exactly one cycle, the cycle in which row 15 is presented.
- R7: A `start` pulse that arrives while a block is in progress starts nothing. Neither it nor any change to the neighbour inputs after capture alters the remaining rows, and no row follows row 15.
- R8: Above sample i is `top_row[8i+7:8i]`, left sample j is `left_col[8j+7:8j]`, and output column x of the current row is `row_px[8x+7:8x]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a prediction; ignored while busy |
| top_row | input | 128 | Sixteen above samples, sample 0 in the low byte |
| left_col | input | 128 | Sixteen left samples, sample 0 in the low byte |
| corner | input | 8 | Above-left corner sample |
| row_valid | output | 1 | `row_px` holds a predicted row |
| row_idx | output | 4 | Number of the row on `row_px` |
| row_px | output | 128 | Sixteen predicted samples, column 0 in the low byte |
| done | output | 1 | High with the last row |

## Verification
A flat neighbourhood gives zero slopes and must return the input level everywhere, which isolates the offset and rounding terms. A horizontal ramp and a vertical ramp each drive one slope while the other stays zero, so a swapped or mis-weighted tap shows up on one axis only. Steep opposing edges push the surface below 0 and above 8191, which tests both clamp limits and the sign-keeping shift on negative gradients. Pseudo-random neighbourhoods mix all terms. One run also changes the inputs and pulses `start` in the middle of the output burst, which shows that capture happens once and that a restart is refused.

// File: rtl/plane_pkg.sv
// plane_pkg: constants shared by the plane predictor. The gradient taps and
// rounding constants only hold for a 16-sample edge, so the edge length is
// fixed here and every derived count comes from it.
package plane_pkg;
    localparam int EDGE      = 16;             // samples per block edge
    localparam int HALF      = EDGE / 2;       // taps per gradient sum
    localparam int IDX_W     = $clog2(EDGE);   // row counter width
    localparam int SLOPE_MUL = 5;              // slope scale numerator
    localparam int SLOPE_RND = 32;             // slope rounding term
    localparam int SLOPE_SH  = 6;              // slope scale shift
    localparam int FRAC_SH   = 5;              // final output shift
    localparam int OFS_RND   = 16;             // output rounding term
endpackage

// File: rtl/plane_px_clip.sv
// plane_px_clip: converts one signed pre-scale value into an output sample.
// The value is clamped to 0 .. 2^(PIX_W+FRAC)-1 and then the FRAC fraction
// bits are dropped. Purely combinational. Assumes ACC_W > PIX_W + FRAC.
module plane_px_clip #(
    parameter int PIX_W = 8,
    parameter int ACC_W = 18,
    parameter int FRAC  = 5
) (
    input  logic signed [ACC_W-1:0] pre_val,
    output logic        [PIX_W-1:0] pix
);
    localparam int TOP_W = PIX_W + FRAC;
    localparam logic signed [ACC_W-1:0] MAX_PRE = ACC_W'((1 << TOP_W) - 1);

    // Clamp to the representable range, then take the integer part.
    always_comb begin
        if (pre_val < 0)
            pix = '0;
        else if (pre_val > MAX_PRE)
            pix = '1;
        else
            pix = pre_val[FRAC +: PIX_W];
    end
endmodule

// File: rtl/plane_grad_fit.sv
// plane_grad_fit: derives the plane slopes and the top-left start value.
// Stage 1 captures the neighbours on launch and forms the weighted edge
// differences and the corner-sum offset. Stage 2 applies rounded scaling and
// forms the start value. params_vld pulses two edges after launch. Assumes
// launch is only raised while no earlier result is still being consumed.
module plane_grad_fit
    import plane_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int ACC_W = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     launch,
    input  logic [EDGE*PIX_W-1:0]    top_row,
    input  logic [EDGE*PIX_W-1:0]    left_col,
    input  logic [PIX_W-1:0]         corner,
    output logic                     params_vld,
    output logic signed [ACC_W-1:0]  slope_x,
    output logic signed [ACC_W-1:0]  slope_y,
    output logic signed [ACC_W-1:0]  origin
);
    localparam int PAD = ACC_W - PIX_W;

    logic signed [ACC_W-1:0] h_term [HALF];
    logic signed [ACC_W-1:0] v_term [HALF];
    logic signed [ACC_W-1:0] h_sum, v_sum, ofs_sum;
    logic signed [ACC_W-1:0] h_q, v_q, ofs_q;
    logic                    s1_vld;
    logic signed [ACC_W-1:0] h_scaled, v_scaled, b_n, c_n, d_n;

    // One weighted difference per tap distance, for both edges.
    for (genvar k = 1; k <= HALF; k++) begin : g_tap
        localparam int HI = HALF - 1 + k;
        localparam int LO = HALF - 1 - k;
        logic [PIX_W-1:0] t_hi, t_lo, l_hi, l_lo;
        assign t_hi = top_row[HI*PIX_W +: PIX_W];
        assign l_hi = left_col[HI*PIX_W +: PIX_W];
        if (LO < 0) begin : g_corner
            assign t_lo = corner;
            assign l_lo = corner;
        end else begin : g_edge
            assign t_lo = top_row[LO*PIX_W +: PIX_W];
            assign l_lo = left_col[LO*PIX_W +: PIX_W];
        end
        assign h_term[k-1] = $signed(ACC_W'(k)) *
            ($signed({{PAD{1'b0}}, t_hi}) - $signed({{PAD{1'b0}}, t_lo}));
        assign v_term[k-1] = $signed(ACC_W'(k)) *
            ($signed({{PAD{1'b0}}, l_hi}) - $signed({{PAD{1'b0}}, l_lo}));
    end

    // Sum the taps and form the far-corner offset.
    always_comb begin
        h_sum = '0;
        v_sum = '0;
        for (int i = 0; i < HALF; i++) begin
            h_sum = h_sum + h_term[i];
            v_sum = v_sum + v_term[i];
        end
        ofs_sum = ($signed({{PAD{1'b0}}, top_row[(EDGE-1)*PIX_W +: PIX_W]}) +
                   $signed({{PAD{1'b0}}, left_col[(EDGE-1)*PIX_W +: PIX_W]})) <<< 4;
    end

    // Stage 1 register: raw gradients and offset, captured on launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            h_q    <= '0;
            v_q    <= '0;
            ofs_q  <= '0;
        end else begin
            s1_vld <= launch;
            if (launch) begin
                h_q   <= h_sum;
                v_q   <= v_sum;
                ofs_q <= ofs_sum;
            end
        end
    end

    // Rounded slope scaling and the start value at column 0, row 0.
    always_comb begin
        h_scaled = $signed(ACC_W'(SLOPE_MUL)) * h_q + $signed(ACC_W'(SLOPE_RND));
        v_scaled = $signed(ACC_W'(SLOPE_MUL)) * v_q + $signed(ACC_W'(SLOPE_RND));
        b_n      = h_scaled >>> SLOPE_SH;
        c_n      = v_scaled >>> SLOPE_SH;
        d_n      = ofs_q - ((b_n <<< 3) - b_n) - ((c_n <<< 3) - c_n)
                 + $signed(ACC_W'(OFS_RND));
    end

    // Stage 2 register: final parameters and their valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            params_vld <= 1'b0;
            slope_x    <= '0;
            slope_y    <= '0;
            origin     <= '0;
        end else begin
            params_vld <= s1_vld;
            if (s1_vld) begin
                slope_x <= b_n;
                slope_y <= c_n;
                origin  <= d_n;
            end
        end
    end

    // R2: parameters are ready a fixed two edges after launch.
    a_r2_param_latency: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> ##2 params_vld);

    // R3: a flat neighbourhood (zero gradient sum) yields zero slope.
    a_r3_flat_slope: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && h_q == '0) |=> (slope_x == '0));
endmodule

// File: rtl/plane_row_gen.sv
// plane_row_gen: walks the plane one row per cycle. Column values come from
// an adder chain seeded with the row base, and the row base advances by the
// vertical slope. Starts on params_vld and emits EDGE consecutive rows.
// Assumes params_vld never arrives while a burst is running.
module plane_row_gen
    import plane_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int ACC_W = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     params_vld,
    input  logic signed [ACC_W-1:0]  slope_x,
    input  logic signed [ACC_W-1:0]  slope_y,
    input  logic signed [ACC_W-1:0]  origin,
    output logic                     row_valid,
    output logic [IDX_W-1:0]         row_idx,
    output logic [EDGE*PIX_W-1:0]    row_px,
    output logic                     done
);
    logic                    active;
    logic [IDX_W-1:0]        cnt;
    logic signed [ACC_W-1:0] row_acc;
    logic signed [ACC_W-1:0] base;
    logic                    emit;
    logic signed [ACC_W-1:0] col_val [EDGE];
    logic [EDGE*PIX_W-1:0]   px_next;

    // Row base: the fresh start value on the first row, else the accumulator.
    always_comb begin
        base = params_vld ? origin : row_acc;
        emit = params_vld | active;
    end

    // Column adder chain and per-column clamp.
    for (genvar x = 0; x < EDGE; x++) begin : g_col
        if (x == 0) begin : g_first
            assign col_val[x] = base;
        end else begin : g_next
            assign col_val[x] = col_val[x-1] + slope_x;
        end
        plane_px_clip #(
            .PIX_W (PIX_W),
            .ACC_W (ACC_W),
            .FRAC  (FRAC_SH)
        ) u_clip (
            .pre_val (col_val[x]),
            .pix     (px_next[x*PIX_W +: PIX_W])
        );
    end

    // Burst sequencing: row counter, accumulator and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cnt       <= '0;
            row_acc   <= '0;
            row_valid <= 1'b0;
            row_idx   <= '0;
            row_px    <= '0;
            done      <= 1'b0;
        end else begin
            row_valid <= emit;
            done      <= active && (cnt == IDX_W'(EDGE - 1));
            if (emit) begin
                row_px  <= px_next;
                row_idx <= params_vld ? '0 : cnt;
                row_acc <= base + slope_y;
            end
            if (params_vld) begin
                active <= 1'b1;
                cnt    <= IDX_W'(1);
            end else if (active) begin
                cnt <= cnt + 1'b1;
                if (cnt == IDX_W'(EDGE - 1))
                    active <= 1'b0;
            end
        end
    end

    // R7: a new parameter set never lands inside a running burst.
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        params_vld |-> !active);

    // R2: the first row after new parameters is row 0.
    a_r2_first_row: assert property (@(posedge clk) disable iff (!rst_n)
        params_vld |=> (row_valid && row_idx == '0));
endmodule

// File: rtl/intra_plane16_pred.sv
// intra_plane16_pred: top of the 16x16 plane predictor. Accepts start only
// when idle, runs the two-cycle parameter fit, then the sixteen-row burst.
// Assumes neighbour inputs are stable on the edge where start is accepted.
module intra_plane16_pred
    import plane_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int ACC_W = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [EDGE*PIX_W-1:0] top_row,
    input  logic [EDGE*PIX_W-1:0] left_col,
    input  logic [PIX_W-1:0]      corner,
    output logic                  row_valid,
    output logic [IDX_W-1:0]      row_idx,
    output logic [EDGE*PIX_W-1:0] row_px,
    output logic                  done
);
    logic                    busy;
    logic                    launch;
    logic                    params_vld;
    logic signed [ACC_W-1:0] slope_x, slope_y, origin;

    assign launch = start & ~busy;

    // Busy from an accepted start until the last row has been presented.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (launch)
            busy <= 1'b1;
        else if (done)
            busy <= 1'b0;
    end

    plane_grad_fit #(
        .PIX_W (PIX_W),
        .ACC_W (ACC_W)
    ) u_fit (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .top_row    (top_row),
        .left_col   (left_col),
        .corner     (corner),
        .params_vld (params_vld),
        .slope_x    (slope_x),
        .slope_y    (slope_y),
        .origin     (origin)
    );

    plane_row_gen #(
        .PIX_W (PIX_W),
        .ACC_W (ACC_W)
    ) u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .params_vld (params_vld),
        .slope_x    (slope_x),
        .slope_y    (slope_y),
        .origin     (origin),
        .row_valid  (row_valid),
        .row_idx    (row_idx),
        .row_px     (row_px),
        .done       (done)
    );

    // R6: done marks row 15 only.
    a_r6_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (row_valid && row_idx == IDX_W'(EDGE - 1)));

    // R6: done lasts a single cycle.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: rows are contiguous and numbered in order until done.
    a_r2_rows_contig: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && !done) |=> (row_valid && row_idx == $past(row_idx) + 1'b1));

    // R7: a start seen while busy is not launched.
    a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/intra_plane16_pred_test.sv
module intra_plane16_pred_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] top_row = '0;
    logic [127:0] left_col = '0;
    logic [7:0]   corner = '0;
    logic         row_valid;
    logic [3:0]   row_idx;
    logic [127:0] row_px;
    logic         done;

    int errors = 0;
    int checks = 0;
    int t[16];
    int l[16];
    int cn;
    int seed = 32'h1234_5678;
    logic [127:0] exp_row[16];

    always #(CLK_PERIOD/2) clk = ~clk;

    intra_plane16_pred uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .top_row   (top_row),
        .left_col  (left_col),
        .corner    (corner),
        .row_valid (row_valid),
        .row_idx   (row_idx),
        .row_px    (row_px),
        .done      (done)
    );

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Clamp to 0..8191, then drop five fraction bits (R5).
    function automatic int clip8(int v);
        if (v < 0) return 0;
        if (v > 8191) return 255;
        return v >> 5;
    endfunction

    function automatic int rnd8();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 255;
    endfunction

    // Reference: direct plane formula from R3/R4/R5, packing per R8.
    task automatic build();
        int h, v, a, b, c;
        h = 0;
        v = 0;
        for (int k = 1; k <= 8; k++) begin
            h += k * (t[7+k] - ((k == 8) ? cn : t[7-k]));
            v += k * (l[7+k] - ((k == 8) ? cn : l[7-k]));
        end
        a = 16 * (t[15] + l[15]);
        b = (5 * h + 32) >>> 6;
        c = (5 * v + 32) >>> 6;
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++)
                exp_row[y][8*x +: 8] = 8'(clip8(a + b*(x-7) + c*(y-7) + 16));
        for (int i = 0; i < 16; i++) begin
            top_row[8*i +: 8]  = 8'(t[i]);
            left_col[8*i +: 8] = 8'(l[i]);
        end
        corner = 8'(cn);
    endtask

    // One block: pulse start, then compare every cycle of the burst window.
    task automatic run(bit poke);
        bit ev;
        @(negedge clk);
        build();
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int s = 1; s <= 21; s++) begin
            ev = (s >= 3 && s <= 18);
            check(row_valid == ev, poke ? "R7 row_valid after late start" : "R2 row_valid timing",
                  128'(row_valid), 128'(ev));
            check(done == (s == 18), "R6 done pulse", 128'(done), 128'(s == 18));
            if (ev) begin
                check(row_idx == 4'(s - 3), "R2 row_idx", 128'(row_idx), 128'(s - 3));
                check(row_px == exp_row[s-3],
                      poke ? "R7 R3 R4 R5 R8 row pixels" : "R3 R4 R5 R8 row pixels",
                      row_px, exp_row[s-3]);
            end
            if (poke && s == 8) begin
                top_row  = ~top_row;
                left_col = ~left_col;
                corner   = ~corner;
                start    = 1'b1;
            end
            if (poke && s == 9) start = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(row_valid == 1'b0, "R1 row_valid in reset", 128'(row_valid), 128'(0));
        check(done == 1'b0, "R1 done in reset", 128'(done), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(row_valid == 1'b0 && done == 1'b0, "R1 idle after reset",
              128'({row_valid, done}), 128'(0));

        // Flat neighbourhood.
        for (int i = 0; i < 16; i++) begin t[i] = 100; l[i] = 100; end
        cn = 100;
        run(1'b0);
        // Horizontal ramp.
        for (int i = 0; i < 16; i++) begin t[i] = 16 * i; l[i] = 50; end
        cn = 40;
        run(1'b0);
        // Vertical ramp.
        for (int i = 0; i < 16; i++) begin t[i] = 60; l[i] = 255 - 15 * i; end
        cn = 200;
        run(1'b0);
        // Opposing steep edges: both clamp limits.
        for (int i = 0; i < 16; i++) begin t[i] = (i < 8) ? 0 : 255; l[i] = (i < 8) ? 255 : 0; end
        cn = 0;
        run(1'b0);
        for (int i = 0; i < 16; i++) begin t[i] = 255 - 17 * i; l[i] = 17 * i; end
        cn = 255;
        run(1'b0);
        // Pseudo-random neighbourhoods, one with a late start and input change.
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 16; i++) begin t[i] = rnd8(); l[i] = rnd8(); end
            cn = rnd8();
            run(r == 2);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule